// File: doc/BRIEF.md
# Data-Processing Unit with Condition Flags

This block is the arithmetic and logic stage of a 32-bit integer pipeline. Each cycle it takes a 4-bit operation code and a first operand. It also takes a second operand that an external shifter has already shifted or rotated, together with that shifter's carry-out. It receives the current condition flags and a request to update them. It produces the operation result, a destination write enable, and the next value of the four condition flags: negative, zero, carry and overflow. All three outputs are registered, so they appear one clock after the inputs.

There are sixteen operations. Six are logical, six are arithmetic, and four are compare forms that only affect the flags. The two classes set carry in different ways. Arithmetic operations take carry from the adder. Logical operations take carry from the shifter, and keep overflow unchanged. For an immediate second operand that was not rotated, a logical operation keeps the old carry. The adder can be built as a behavioural sum or as an explicit ripple chain, chosen by a parameter.

Top module: `dp_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears `res_q`, `wr_en_q` and `flags_q` to zero on the next rising edge.
- R2: The outputs reflect the inputs present at the previous rising edge. The flag vector is ordered {N, Z, C, V}, with N at bit 3 and V at bit 0.
- R3: The logical operation codes are:
  - 0x0: a AND b
  - 0x1: a XOR b
  - 0xC: a OR b
  - 0xD: b
  - 0xE: a AND NOT b
  - 0xF: NOT b
- R4: The arithmetic operation codes are:
  - 0x2: a-b
  - 0x3: b-a
  - 0x4: a+b
  - 0x5: a+b+C
  - 0x6: a-b-(1-C)
  - 0x7: b-a-(1-C)

  All results are taken modulo 2^32, and C is the incoming carry flag.
- R5: The compare codes are 0x8 (a AND b), 0x9 (a XOR b), 0xA (a-b) and 0xB (a+b). They drive `wr_en_q` low, and `res_q` still carries the computed value. Every other code drives `wr_en_q` high.
- R6: The flags are recomputed only when `set_flags` is high or the code is a compare form. Otherwise `flags_q` takes the value of `flags_in`.
- R7: When the flags are recomputed, N equals bit 31 of the result and Z is 1 exactly when the result is zero.
- R8: For arithmetic and compare-arithmetic codes, C is the adder carry-out and V is signed overflow. Subtraction is done as addition of the inverted operand, so C=1 means no borrow.
- R9: For logical and compare-logical codes, V keeps `flags_in` V. C takes `shift_cout` when `imm_form` is low, or when `imm_form` and `imm_rotated` are both high.
- R10: For logical and compare-logical codes with `imm_form` high and `imm_rotated` low, C keeps `flags_in` C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already shifted or rotated |
| shift_cout | input | 1 | Carry-out of the external shifter |
| imm_form | input | 1 | Second operand is an immediate |
| imm_rotated | input | 1 | The immediate had a nonzero rotation |
| set_flags | input | 1 | Request a flag update |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| res_q | output | 32 | Registered result |
| wr_en_q | output | 1 | Registered destination write enable |
| flags_q | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
Two functions can fall in the same cycle: reading the incoming carry as an operand and producing a new carry. This happens for add-with-carry, subtract-with-carry and reverse-subtract-with-carry when `set_flags` is high. The bench provokes it with both values of the incoming carry on boundary operands such as zero, all-ones and the sign bit alone. It judges the result and the new carry together against a behavioural model. The other overlap is a compare code with `set_flags` low, where the flag update must win over the hold path while the write enable stays low. Random traffic mixes all sixteen codes with every combination of the control inputs, and the outputs are compared with the model on every clock.

// File: rtl/dpu_pkg.sv
package dpu_pkg;
   typedef enum logic [3:0] {
      OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
      OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
      OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
      OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
   } dp_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

   function automatic logic op_is_compare(input logic [3:0] op);
      return (op[3:2] == 2'b10);
   endfunction

   function automatic logic op_is_logical(input logic [3:0] op);
      return (op == OP_AND) || (op == OP_EOR) || (op == OP_TST) || (op == OP_TEQ) ||
             (op[3:2] == 2'b11);
   endfunction
endpackage

// File: rtl/dpu_logic.sv
module dpu_logic #(
   parameter int W = 32
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res
);
   import dpu_pkg::*;

   always_comb begin
      unique case (op)
         OP_AND, OP_TST: res = a & b;
         OP_EOR, OP_TEQ: res = a ^ b;
         OP_ORR:         res = a | b;
         OP_MOV:         res = b;
         OP_BIC:         res = a & ~b;
         OP_MVN:         res = ~b;
         default:        res = '0;
      endcase
   end
endmodule

// File: rtl/dpu_addsub.sv
module dpu_addsub #(
   parameter int W      = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         c_flag,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   import dpu_pkg::*;

   logic [W-1:0] x, y;
   logic         cin;

   // operand steering: subtraction adds the inverted subtrahend
   always_comb begin
      x   = a;
      y   = b;
      cin = 1'b0;
      unique case (op)
         OP_SUB, OP_CMP: begin y = ~b; cin = 1'b1;   end
         OP_RSB:         begin x = b; y = ~a; cin = 1'b1; end
         OP_ADD, OP_CMN: begin cin = 1'b0;           end
         OP_ADC:         begin cin = c_flag;         end
         OP_SBC:         begin y = ~b; cin = c_flag; end
         OP_RSC:         begin x = b; y = ~a; cin = c_flag; end
         default:        begin cin = 1'b0;           end
      endcase
   end

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] cy;
         assign cy[0] = cin;
         for (genvar gi = 0; gi < W; gi++) begin : g_bit
            assign sum[gi]  = x[gi] ^ y[gi] ^ cy[gi];
            assign cy[gi+1] = (x[gi] & y[gi]) | (cy[gi] & (x[gi] ^ y[gi]));
         end
         assign cout = cy[W];
         assign ovf  = cy[W] ^ cy[W-1];
      end else begin : g_behav
         logic [W:0] wide;
         assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
         assign sum  = wide[W-1:0];
         assign cout = wide[W];
         assign ovf  = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);
      end
   endgenerate
endmodule

// File: rtl/dpu_flags.sv
module dpu_flags #(
   parameter int W = 32
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] res,
   input  logic         add_cout,
   input  logic         add_ovf,
   input  logic         shift_cout,
   input  logic         imm_form,
   input  logic         imm_rotated,
   input  logic         set_flags,
   input  logic [3:0]   flags_in,
   output logic [3:0]   flags_nx,
   output logic         wr_en
);
   import dpu_pkg::*;

   nzcv_t cur, nxt;
   logic  logical, compare, update, shc_used;

   assign cur      = nzcv_t'(flags_in);
   assign logical  = op_is_logical(op);
   assign compare  = op_is_compare(op);
   assign update   = set_flags | compare;
   assign shc_used = ~imm_form | imm_rotated;
   assign wr_en    = ~compare;

   always_comb begin
      nxt = cur;
      if (update) begin
         nxt.n = res[W-1];
         nxt.z = (res == '0);
         if (logical) begin
            nxt.c = shc_used ? shift_cout : cur.c;
            nxt.v = cur.v;
         end else begin
            nxt.c = add_cout;
            nxt.v = add_ovf;
         end
      end
   end

   assign flags_nx = nxt;
endmodule

// File: rtl/dp_flag_unit.sv
module dp_flag_unit #(
   parameter int W      = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [3:0]   op_code,
   input  logic [31:0]  opnd_a,
   input  logic [31:0]  opnd_b,
   input  logic         shift_cout,
   input  logic         imm_form,
   input  logic         imm_rotated,
   input  logic         set_flags,
   input  logic [3:0]   flags_in,
   output logic [31:0]  res_q,
   output logic         wr_en_q,
   output logic [3:0]   flags_q
);
   import dpu_pkg::*;

   localparam int MSB = W - 1;

   generate
      if (W != 32) begin : g_bad_width
         $error("dp_flag_unit: port width is fixed at 32, W must match");
      end
   endgenerate

   logic [W-1:0] logic_res, arith_res, res_d;
   logic         add_cout, add_ovf, wr_en_d;
   logic [3:0]   flags_d;

   dpu_logic #(.W(W)) i_logic (
      .op (op_code), .a (opnd_a), .b (opnd_b), .res (logic_res)
   );

   dpu_addsub #(.W(W), .RIPPLE(RIPPLE)) i_addsub (
      .op (op_code), .a (opnd_a), .b (opnd_b), .c_flag (flags_in[1]),
      .sum (arith_res), .cout (add_cout), .ovf (add_ovf)
   );

   assign res_d = op_is_logical(op_code) ? logic_res : arith_res;

   dpu_flags #(.W(W)) i_flags (
      .op (op_code), .res (res_d), .add_cout (add_cout), .add_ovf (add_ovf),
      .shift_cout (shift_cout), .imm_form (imm_form), .imm_rotated (imm_rotated),
      .set_flags (set_flags), .flags_in (flags_in),
      .flags_nx (flags_d), .wr_en (wr_en_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q   <= '0;
         wr_en_q <= 1'b0;
         flags_q <= '0;
      end else begin
         res_q   <= res_d;
         wr_en_q <= wr_en_d;
         flags_q <= flags_d;
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (flags_q == 4'h0 && !wr_en_q && res_q == '0)); // R1
   AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (!rst && op_code[3:2] == 2'b10) |=> !wr_en_q); // R5
   AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
      (!rst && !set_flags && op_code[3:2] != 2'b10) |=> flags_q == $past(flags_in)); // R6
   AST_N_TRACK: assert property (@(posedge clk) disable iff (rst)
      (!rst && (set_flags || op_code[3:2] == 2'b10)) |=> flags_q[3] == res_q[MSB]); // R7
   AST_Z_TRACK: assert property (@(posedge clk) disable iff (rst)
      (!rst && (set_flags || op_code[3:2] == 2'b10)) |=> flags_q[2] == (res_q == '0)); // R7
   AST_LOGIC_V_KEPT: assert property (@(posedge clk) disable iff (rst)
      (!rst && op_is_logical(op_code)) |=> flags_q[0] == $past(flags_in[0])); // R9
   AST_IMM_C_KEPT: assert property (@(posedge clk) disable iff (rst)
      (!rst && op_is_logical(op_code) && imm_form && !imm_rotated)
      |=> flags_q[1] == $past(flags_in[1])); // R10
endmodule

// File: tb/test_dp_flag_unit.sv
module test_dp_flag_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  op_code = '0;
   logic [31:0] opnd_a = '0, opnd_b = '0;
   logic        shift_cout = 1'b0, imm_form = 1'b0, imm_rotated = 1'b0, set_flags = 1'b0;
   logic [3:0]  flags_in = '0;
   logic [31:0] res_q;
   logic        wr_en_q;
   logic [3:0]  flags_q;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   typedef struct {
      logic [31:0] res;
      logic        we;
      logic [3:0]  fl;
      string       tag;
   } exp_t;
   exp_t expq[$];

   always #5 clk = ~clk;

   dp_flag_unit i_dp_flag_unit (
      .clk (clk), .rst (rst), .op_code (op_code), .opnd_a (opnd_a), .opnd_b (opnd_b),
      .shift_cout (shift_cout), .imm_form (imm_form), .imm_rotated (imm_rotated),
      .set_flags (set_flags), .flags_in (flags_in),
      .res_q (res_q), .wr_en_q (wr_en_q), .flags_q (flags_q)
   );

   // behavioural reference
   function automatic exp_t model(input logic [3:0] op, input logic [31:0] a, b,
                                  input logic shc, imm, rot, sf, input logic [3:0] fl);
      exp_t e;
      longint unsigned ua = a, ub = b, s;
      logic c_in = fl[1];
      logic is_log = 0, is_cmp = 0, ac = 0, av = 0;
      longint unsigned ox = 0, oy = 0, ci = 0;
      logic [31:0] r = 0;
      case (op)
         4'h0: begin r = a & b;  is_log = 1; end
         4'h1: begin r = a ^ b;  is_log = 1; end
         4'h8: begin r = a & b;  is_log = 1; is_cmp = 1; end
         4'h9: begin r = a ^ b;  is_log = 1; is_cmp = 1; end
         4'hC: begin r = a | b;  is_log = 1; end
         4'hD: begin r = b;      is_log = 1; end
         4'hE: begin r = a & ~b; is_log = 1; end
         4'hF: begin r = ~b;     is_log = 1; end
         default: begin
            case (op)
               4'h2, 4'hA: begin ox = ua; oy = ub ^ 32'hFFFF_FFFF; ci = 1; end
               4'h3:       begin ox = ub; oy = ua ^ 32'hFFFF_FFFF; ci = 1; end
               4'h4, 4'hB: begin ox = ua; oy = ub; ci = 0; end
               4'h5:       begin ox = ua; oy = ub; ci = c_in; end
               4'h6:       begin ox = ua; oy = ub ^ 32'hFFFF_FFFF; ci = c_in; end
               default:    begin ox = ub; oy = ua ^ 32'hFFFF_FFFF; ci = c_in; end
            endcase
            is_cmp = (op == 4'hA) || (op == 4'hB);
            s  = ox + oy + ci;
            r  = s[31:0];
            ac = s[32];
            av = (ox[31] == oy[31]) && (s[31] != ox[31]);
         end
      endcase
      e.res = r;
      e.we  = !is_cmp;
      e.fl  = fl;
      if (sf || is_cmp) begin
         e.fl[3] = r[31];
         e.fl[2] = (r == 0);
         if (is_log) e.fl[1] = (!imm || rot) ? shc : fl[1];
         else begin e.fl[1] = ac; e.fl[0] = av; end
      end
      return e;
   endfunction

   task automatic drive(input logic [3:0] op, input logic [31:0] a, b,
                        input logic shc, imm, rot, sf, input logic [3:0] fl, input string tag);
      exp_t e;
      op_code = op; opnd_a = a; opnd_b = b; shift_cout = shc;
      imm_form = imm; imm_rotated = rot; set_flags = sf; flags_in = fl;
      e = model(op, a, b, shc, imm, rot, sf, fl);
      e.tag = tag;
      expq.push_back(e);
      @(posedge clk);
      @(negedge clk);
      check_out();
   endtask

   task automatic check_out();
      exp_t e = expq.pop_front();
      total++;
      if (res_q !== e.res || wr_en_q !== e.we || flags_q !== e.fl) begin
         bad++;
         $display("FAIL %s: got res=%h we=%b fl=%b expected res=%h we=%b fl=%b",
                  e.tag, res_q, wr_en_q, flags_q, e.res, e.we, e.fl);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: got running expected finished");
      finish_run();
   end

   function automatic logic [31:0] pick();
      case ($urandom_range(0, 5))
         0: return 32'h0;
         1: return 32'hFFFF_FFFF;
         2: return 32'h8000_0000;
         3: return 32'h7FFF_FFFF;
         default: return $urandom;
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      total++;
      if (res_q !== 0 || wr_en_q !== 0 || flags_q !== 0) begin
         bad++;
         $display("FAIL R1: got res=%h we=%b fl=%b expected zeros", res_q, wr_en_q, flags_q);
      end
      rst = 1'b0;

      // R3 logical results, R2 one-cycle latency and bit order
      drive(4'h0, 32'hF0F0_1234, 32'h0FF0_FFFF, 0, 0, 0, 1, 4'h0, "R3 AND");
      drive(4'h1, 32'hAAAA_5555, 32'hFFFF_0000, 1, 0, 0, 1, 4'h1, "R3 EOR");
      drive(4'hC, 32'h1200_0000, 32'h0000_0034, 0, 0, 0, 0, 4'h5, "R3 ORR");
      drive(4'hD, 32'h1111_1111, 32'h8000_0000, 1, 0, 0, 1, 4'h0, "R3 MOV R2");
      drive(4'hE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 1, 4'hF, "R3 BIC R7 zero");
      drive(4'hF, 32'h0, 32'h0, 0, 0, 0, 1, 4'h0, "R3 MVN R7 neg");
      // R4 arithmetic, R8 carries and overflow
      drive(4'h2, 32'h5, 32'h5, 0, 0, 0, 1, 4'h0, "R4 SUB equal R8");
      drive(4'h2, 32'h0, 32'h1, 0, 0, 0, 1, 4'h0, "R4 SUB borrow R8");
      drive(4'h3, 32'h1, 32'h8000_0000, 0, 0, 0, 1, 4'h0, "R4 RSB ovf R8");
      drive(4'h4, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 1, 4'h0, "R4 ADD ovf R8");
      drive(4'h4, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 1, 4'h0, "R4 ADD carry R8");
      // carry read and carry produced in the same cycle
      drive(4'h5, 32'hFFFF_FFFF, 32'h0, 0, 0, 0, 1, 4'h2, "R4 ADC cin1 R8");
      drive(4'h5, 32'hFFFF_FFFF, 32'h0, 0, 0, 0, 1, 4'h0, "R4 ADC cin0 R8");
      drive(4'h6, 32'h0, 32'h0, 0, 0, 0, 1, 4'h0, "R4 SBC cin0 R8");
      drive(4'h6, 32'h0, 32'h0, 0, 0, 0, 1, 4'h2, "R4 SBC cin1 R8");
      drive(4'h7, 32'h3, 32'h3, 0, 0, 0, 1, 4'h0, "R4 RSC cin0 R8");
      drive(4'h7, 32'h8000_0000, 32'h0, 0, 0, 0, 1, 4'h2, "R4 RSC cin1 R8");
      // R5 compare forms with set_flags low
      drive(4'h8, 32'hF0, 32'h0F, 1, 0, 0, 0, 4'h1, "R5 TST");
      drive(4'h9, 32'h8000_0001, 32'h1, 0, 0, 0, 0, 4'h3, "R5 TEQ");
      drive(4'hA, 32'h2, 32'h3, 0, 0, 0, 0, 4'h0, "R5 CMP");
      drive(4'hB, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 4'h0, "R5 CMN");
      // R6 hold
      drive(4'h4, 32'hFFFF_FFFF, 32'h1, 1, 0, 0, 0, 4'hA, "R6 ADD hold");
      drive(4'h0, 32'h0, 32'h0, 1, 0, 0, 0, 4'h5, "R6 AND hold");
      // R9 shifter carry, V kept
      drive(4'hD, 32'h0, 32'h4, 1, 0, 0, 1, 4'h1, "R9 reg form");
      drive(4'hC, 32'h0, 32'h4, 0, 1, 1, 1, 4'h3, "R9 imm rotated");
      // R10 imm without rotation keeps C
      drive(4'hD, 32'h0, 32'h4, 0, 1, 0, 1, 4'h2, "R10 keep C1");
      drive(4'h8, 32'h1, 32'h1, 1, 1, 0, 0, 4'h0, "R10 keep C0");

      // mixed random traffic
      for (int i = 0; i < 2000; i++) begin
         drive(4'($urandom), pick(), pick(), 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), 4'($urandom), "R2 R4 R8 random");
      end

      // R1: reset in the middle of traffic
      rst = 1'b1;
      op_code = 4'h4; set_flags = 1'b1; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h1;
      @(posedge clk);
      @(negedge clk);
      total++;
      if (res_q !== 0 || wr_en_q !== 0 || flags_q !== 0) begin
         bad++;
         $display("FAIL R1 mid-run: got res=%h we=%b fl=%b expected zeros", res_q, wr_en_q, flags_q);
      end
      finish_run();
   end
endmodule